// File: doc/BRIEF.md
# Lock-Step Cluster Grouping Controller

This block decides, for a row of processing cores, which cores share one instruction front end. The cores are split into clusters of `CLUSTER_SIZE` neighbours. Each kernel launch groups every full cluster. The lowest-indexed core of a cluster is its master, and the master's front end serves the whole cluster. The other members become slaves, and their front ends may be power-gated. Any cores left over after the last full cluster always run on their own.

While a kernel runs, the block compares the next program counter of every member with the master's, in the same cycle. The first mismatch dissolves that cluster. In that same cycle its cores are reported as independent, its slave gate enables drop, and a single-cycle ungroup pulse is raised for that cluster. A dissolved cluster stays apart until the kernel ends. The next kernel launch regroups every cluster, including one that split in the previous kernel.

Top module: `fe_share_grouper`

## Requirements
- R1: After reset, every core reports mode 2'b00 (independent), every gate enable is 0 and every ungroup pulse is 0.
- R2: In the cycle after `kernel_start`, each full cluster reports its lowest-index core as master (2'b01) and its other members as slaves (2'b10), unless that cluster diverges in that cycle. Core i owns mode bits [2i+1:2i].
- R3: A gate enable is 1 exactly for the slave cores of a grouped cluster. It is 0 for masters and for independent cores.
- R4: When a grouped cluster sees any member program counter that differs from its master's, in that same cycle all its cores report 2'b00, its gate enables are 0 and its ungroup pulse is 1. The pulse lasts one cycle.
- R5: A dissolved cluster stays independent, with no further pulse, for the rest of the kernel, even when the program counters match again.
- R6: Divergence in one cluster leaves the modes, gate enables and pulse of every other cluster unchanged.
- R7: In the cycle after `kernel_end` (with `kernel_start` low), every core is independent.
- R8: A later `kernel_start` regroups every full cluster, including one that dissolved in the previous kernel.
- R9: Cores above the last full cluster (index >= (N_CORES/CLUSTER_SIZE)*CLUSTER_SIZE) are always independent with gate enable 0, whatever their program counters.
- R10: When `kernel_start` coincides with a divergence, the pulse is still raised in that cycle and the cluster is grouped in the next cycle. When `kernel_start` coincides with `kernel_end`, the start wins.
- R11: Program-counter mismatches in a cluster that is not grouped raise no pulse and change no mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kernel_start | input | 1 | One-cycle kernel launch strobe |
| kernel_end | input | 1 | One-cycle kernel completion strobe |
| core_pc | input | N_CORES*PC_W | Next program counter per core, core i at [i*PC_W +: PC_W] |
| core_mode | output | 2*N_CORES | Per-core mode: 00 independent, 01 master, 10 slave |
| fe_gate_en | output | N_CORES | Front-end power-gate enable per core |
| ungroup_pulse | output | N_CORES/CLUSTER_SIZE | One-cycle dissolve pulse per cluster |

## Verification
Two things can land in one cycle: a divergence in a grouped cluster and a kernel launch. In that case the divergence must still produce its pulse and independent modes at once, and the launch must win the next cycle's state. The bench raises `kernel_start` in the same cycle it puts a mismatched program counter on one slave. It checks the pulse and modes in that cycle, then checks that the cluster is grouped in the next cycle. It also drives start and end together, and expects a grouped result.

// File: rtl/fe_share_pkg.sv
package fe_share_pkg;
   typedef enum logic [1:0] {
      MODE_INDEP  = 2'b00,
      MODE_MASTER = 2'b01,
      MODE_SLAVE  = 2'b10
   } core_mode_e;
endpackage

// File: rtl/fe_share_pc_compare.sv
// Flags any member program counter that differs from member 0 (the master).
module fe_share_pc_compare #(
   parameter int MEMBERS = 4,
   parameter int PC_W    = 16
) (
   input  logic [MEMBERS*PC_W-1:0] member_pc,
   output logic                    any_diff
);
   localparam int N_CMP = MEMBERS - 1;

   logic [N_CMP-1:0] diff_vec;
   logic [PC_W-1:0]  ref_pc;

   assign ref_pc = member_pc[0 +: PC_W];

   for (genvar k = 1; k < MEMBERS; k++) begin : g_cmp
      assign diff_vec[k-1] = (member_pc[k*PC_W +: PC_W] != ref_pc);
   end

   assign any_diff = |diff_vec;
endmodule

// File: rtl/fe_share_cluster.sv
// One sharing cluster: a grouped flag that is armed by launch and cleared by end or divergence.
module fe_share_cluster
   import fe_share_pkg::*;
#(
   parameter int MEMBERS = 4,
   parameter int PC_W    = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    launch,
   input  logic                    finish,
   input  logic [MEMBERS*PC_W-1:0] member_pc,
   output logic [2*MEMBERS-1:0]    member_mode,
   output logic [MEMBERS-1:0]      member_gate,
   output logic                    ungroup
);
   logic grouped_q;
   logic grouped_d;
   logic any_diff;
   logic active;

   fe_share_pc_compare #(
      .MEMBERS (MEMBERS),
      .PC_W    (PC_W)
   ) cmp_i (
      .member_pc (member_pc),
      .any_diff  (any_diff)
   );

   // Divergence is sampled only while grouped; it takes effect in the same cycle.
   assign active  = grouped_q & ~any_diff;
   assign ungroup = grouped_q &  any_diff;

   always_comb begin
      grouped_d = grouped_q;
      if (launch)
         grouped_d = 1'b1;
      else if (finish || any_diff)
         grouped_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         grouped_q <= 1'b0;
      else
         grouped_q <= grouped_d;
   end

   for (genvar k = 0; k < MEMBERS; k++) begin : g_member
      if (k == 0) begin : g_master
         assign member_mode[2*k +: 2] = active ? MODE_MASTER : MODE_INDEP;
         assign member_gate[k]        = 1'b0;
      end else begin : g_slave
         assign member_mode[2*k +: 2] = active ? MODE_SLAVE : MODE_INDEP;
         assign member_gate[k]        = active;
      end
   end
endmodule

// File: rtl/fe_share_grouper.sv
// Top: splits the cores into clusters and ties the trailing cores to independent mode.
module fe_share_grouper
   import fe_share_pkg::*;
#(
   parameter int N_CORES      = 10,
   parameter int CLUSTER_SIZE = 4,
   parameter int PC_W         = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              kernel_start,
   input  logic                              kernel_end,
   input  logic [N_CORES*PC_W-1:0]           core_pc,
   output logic [2*N_CORES-1:0]              core_mode,
   output logic [N_CORES-1:0]                fe_gate_en,
   output logic [N_CORES/CLUSTER_SIZE-1:0]   ungroup_pulse
);
   localparam int N_CLUST   = N_CORES / CLUSTER_SIZE;
   localparam int N_GROUPED = N_CLUST * CLUSTER_SIZE;
   localparam int N_TAIL    = N_CORES - N_GROUPED;

   if (CLUSTER_SIZE < 2) begin : g_bad_size
      $error("CLUSTER_SIZE must be at least 2");
   end
   if (N_CORES < CLUSTER_SIZE) begin : g_bad_count
      $error("N_CORES must hold at least one cluster");
   end
   if (PC_W < 1) begin : g_bad_pc
      $error("PC_W must be positive");
   end

   for (genvar c = 0; c < N_CLUST; c++) begin : g_cluster
      fe_share_cluster #(
         .MEMBERS (CLUSTER_SIZE),
         .PC_W    (PC_W)
      ) clu_i (
         .clk         (clk),
         .rst_n       (rst_n),
         .launch      (kernel_start),
         .finish      (kernel_end),
         .member_pc   (core_pc[c*CLUSTER_SIZE*PC_W +: CLUSTER_SIZE*PC_W]),
         .member_mode (core_mode[2*c*CLUSTER_SIZE +: 2*CLUSTER_SIZE]),
         .member_gate (fe_gate_en[c*CLUSTER_SIZE +: CLUSTER_SIZE]),
         .ungroup     (ungroup_pulse[c])
      );
   end

   if (N_TAIL > 0) begin : g_tail
      for (genvar t = N_GROUPED; t < N_CORES; t++) begin : g_core
         assign core_mode[2*t +: 2] = MODE_INDEP;
         assign fe_gate_en[t]       = 1'b0;
      end
   end
endmodule

// File: rtl/fe_share_grouper_chk.sv
module fe_share_grouper_chk #(
   parameter int N_CORES      = 10,
   parameter int CLUSTER_SIZE = 4
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            kernel_start,
   input logic                            kernel_end,
   input logic [2*N_CORES-1:0]            core_mode,
   input logic [N_CORES-1:0]              fe_gate_en,
   input logic [N_CORES/CLUSTER_SIZE-1:0] ungroup_pulse
);
   localparam int N_CLUST = N_CORES / CLUSTER_SIZE;

   for (genvar i = 0; i < N_CORES; i++) begin : g_core
      // R3
      a_r3_gate_only_slave: assert property (@(posedge clk) disable iff (!rst_n)
         fe_gate_en[i] |-> core_mode[2*i +: 2] == 2'b10);
   end

   for (genvar c = 0; c < N_CLUST; c++) begin : g_clu
      localparam int M = c * CLUSTER_SIZE;
      // R2
      a_r2_master_after_start: assert property (@(posedge clk) disable iff (!rst_n)
         kernel_start |=> (core_mode[2*M +: 2] == 2'b01) || ungroup_pulse[c]);
      // R4
      a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
         ungroup_pulse[c] && !kernel_start |=> !ungroup_pulse[c]);
      // R4
      a_r4_pulse_indep: assert property (@(posedge clk) disable iff (!rst_n)
         ungroup_pulse[c] |-> core_mode[2*M +: 2] == 2'b00);
      // R5
      a_r5_stays_apart: assert property (@(posedge clk) disable iff (!rst_n)
         ungroup_pulse[c] && !kernel_start |=> core_mode[2*M +: 2] == 2'b00);
   end

   // R7
   a_r7_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
      kernel_end && !kernel_start |=> core_mode == '0);
endmodule

bind fe_share_grouper fe_share_grouper_chk #(
   .N_CORES      (N_CORES),
   .CLUSTER_SIZE (CLUSTER_SIZE)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .kernel_start  (kernel_start),
   .kernel_end    (kernel_end),
   .core_mode     (core_mode),
   .fe_gate_en    (fe_gate_en),
   .ungroup_pulse (ungroup_pulse)
);

// File: tb/fe_share_grouper_tb_top.sv
module fe_share_grouper_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N   = 10;
   localparam int S   = 4;
   localparam int W   = 16;
   localparam int NCL = N / S;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               kernel_start = 1'b0;
   logic               kernel_end = 1'b0;
   logic [W-1:0]       pc_a [N];
   logic [N*W-1:0]     core_pc;
   logic [2*N-1:0]     core_mode;
   logic [N-1:0]       fe_gate_en;
   logic [NCL-1:0]     ungroup_pulse;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) core_pc[i*W +: W] = pc_a[i];
   end

   fe_share_grouper #(.N_CORES(N), .CLUSTER_SIZE(S), .PC_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .kernel_start(kernel_start), .kernel_end(kernel_end),
      .core_pc(core_pc), .core_mode(core_mode), .fe_gate_en(fe_gate_en),
      .ungroup_pulse(ungroup_pulse)
   );

   task automatic chk(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Expected per-core mode when cluster c grouped flags are given.
   function automatic int exp_mode(int i, bit [NCL-1:0] grp);
      if (i >= NCL*S) return 0;
      if (!grp[i/S]) return 0;
      return (i % S == 0) ? 1 : 2;
   endfunction

   task automatic chk_all(string tag, bit [NCL-1:0] grp, bit [NCL-1:0] pulse);
      for (int i = 0; i < N; i++) begin
         chk({tag, " mode"}, int'(core_mode[2*i +: 2]), exp_mode(i, grp));
         chk({tag, " gate"}, int'(fe_gate_en[i]), (exp_mode(i, grp) == 2) ? 1 : 0);
      end
      chk({tag, " pulse"}, int'(ungroup_pulse), int'(pulse));
   endtask

   task automatic set_pcs(logic [W-1:0] v);
      for (int i = 0; i < N; i++) pc_a[i] = v;
   endtask

   // Drive at negedge; combinational outputs are checked 1 time unit later.
   task automatic next_cyc();
      @(negedge clk);
      kernel_start = 1'b0;
      kernel_end   = 1'b0;
   endtask

   task automatic t_reset();
      chk_all("R1 reset", 2'b00, 2'b00);
   endtask

   task automatic t_launch();
      next_cyc(); set_pcs(16'h0100); kernel_start = 1'b1;
      next_cyc(); #1;
      chk_all("R2 R3 R9 launch", 2'b11, 2'b00);
      pc_a[8] = 16'h0777; pc_a[9] = 16'h0888; #1;
      chk_all("R9 tail pcs", 2'b11, 2'b00);
   endtask

   task automatic t_diverge();
      next_cyc(); pc_a[8] = 16'h0100; pc_a[9] = 16'h0100; pc_a[2] = 16'h0200; #1;
      chk_all("R4 R6 diverge", 2'b10, 2'b01);
      next_cyc(); pc_a[2] = 16'h0100; #1;
      chk_all("R4 R5 after", 2'b10, 2'b00);
      next_cyc(); pc_a[1] = 16'h0333; #1;
      chk_all("R11 R5 apart", 2'b10, 2'b00);
      next_cyc(); pc_a[1] = 16'h0100; #1;
      chk_all("R5 still apart", 2'b10, 2'b00);
   endtask

   task automatic t_end();
      kernel_end = 1'b1;
      next_cyc(); #1;
      chk_all("R7 end", 2'b00, 2'b00);
      pc_a[5] = 16'h0999; #1;
      chk_all("R11 idle diff", 2'b00, 2'b00);
      pc_a[5] = 16'h0100;
   endtask

   task automatic t_relaunch();
      kernel_start = 1'b1;
      next_cyc(); #1;
      chk_all("R8 relaunch", 2'b11, 2'b00);
   endtask

   task automatic t_start_with_diverge();
      pc_a[6] = 16'h0555; kernel_start = 1'b1; #1;
      chk_all("R10 coincide", 2'b01, 2'b10);
      next_cyc(); pc_a[6] = 16'h0100; #1;
      chk_all("R10 regrouped", 2'b11, 2'b00);
   endtask

   task automatic t_start_with_end();
      kernel_end = 1'b1;
      next_cyc(); #1;
      chk_all("R7 end2", 2'b00, 2'b00);
      kernel_start = 1'b1; kernel_end = 1'b1;
      next_cyc(); #1;
      chk_all("R10 start wins", 2'b11, 2'b00);
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      set_pcs(16'h0000);
      repeat (3) @(posedge clk);
      #1;
      @(negedge clk); rst_n = 1'b1; #1;
      t_reset();
      t_launch();
      t_diverge();
      t_end();
      t_relaunch();
      t_start_with_diverge();
      t_start_with_end();
      done = 1;
      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end
endmodule